// File: doc/BRIEF.md
# Receive Descriptor Ring Poll Controller

This block decides when a network receive engine walks its ring of buffer descriptors in memory. Software writes a 32-bit command register whenever it has handed fresh empty buffers to the ring. Each write arms an active flag. While the flag and the global Ethernet enable are both set, the controller reads descriptors one at a time in ring order. It passes each buffer that software has released to the frame-receive logic, and then writes back the received length and the completion status.

The walk stops on the first descriptor whose empty bit is clear. The controller drops the active flag at that point and waits for the next command write. Dropping the global enable abandons the walk in progress and returns the ring index to the ring base address. Descriptor memory is reached through a valid/ready request port with responses of any latency. The frame-receive side uses a buffer offer handshake and a one-cycle completion strobe.

Top module: `rxring_poll_ctrl`

## Requirements
- R1: Any write to the command register sets the active flag one cycle later, whatever value is written.
- R2: A descriptor read request is issued only while the active flag and the global enable are both set. With the flag clear, no read is issued.
- R3: When a fetched descriptor has its empty bit (status bit 15) clear, the active flag clears and no further descriptor is fetched.
- R4: While the global enable is low, the active flag is clear and stays clear even on a command write. The ring index returns to the base address. A descriptor sequence in progress is abandoned without a writeback.
- R5: The command register reads back with the active flag at bit 24 and every other bit zero. It reads all zeros after reset.
- R6: A descriptor is a 64-bit word laid out as status in bits 63:48, length in bits 47:32 and buffer address in bits 31:0. A fetched descriptor with the empty bit set has its buffer address offered on the buffer port.
- R7: After the frame completes, a write goes to the same descriptor address. It carries the buffer address unchanged, the received length in bits 47:32, and a status with bit 15 clear, bits 14 through ERR_W of the fetched status kept, and the completion error flags in the low ERR_W bits.
- R8: After each writeback the ring index advances by 8 bytes. It returns to the base address instead when the descriptor's wrap bit (status bit 13) is set.
- R9: A command write in the same cycle as a fetch that finds a non-empty descriptor leaves the flag set, so the ring is polled again.
- R10: A memory request stays valid with a stable address, direction and write data until it is accepted. The controller waits for the response however many cycles it takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eth_en | input | 1 | Global Ethernet enable |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command write data (ignored) |
| cmd_rdata | output | 32 | Command register read value |
| ring_base | input | ADDR_W | Byte address of the first descriptor |
| mem_req_valid | output | 1 | Descriptor memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = writeback, 0 = descriptor read |
| mem_req_addr | output | ADDR_W | Descriptor byte address |
| mem_req_wdata | output | 64 | Writeback descriptor word |
| mem_rsp_valid | input | 1 | Memory response strobe |
| mem_rsp_data | input | 64 | Read descriptor word |
| buf_valid | output | 1 | Buffer offered to the frame logic |
| buf_ready | input | 1 | Frame logic takes the buffer |
| buf_addr | output | 32 | Offered buffer address |
| done_valid | input | 1 | Frame completion strobe |
| done_len | input | 16 | Received frame length |
| done_err | input | ERR_W | Completion error flags |

## Verification
A table of four descriptors, with a variable memory latency and back-pressure on requests, exercises writeback merging under different status bit patterns and error flags. It also covers the wrap bit on the last entry and the halt on the first descriptor already written back. This separates correct status merging, length insertion and index wrap from a controller that copies status or ignores the wrap bit. Directed runs separate three things. Arming by the write strobe is checked against arming by the data bit. Set priority during a clear-on-non-empty collision is checked against clear priority. Index reset on enable loss, checked mid-frame, is checked against an index that survives a disable.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
   localparam int DESC_BITS   = 64;
   localparam int DESC_BYTES  = DESC_BITS / 8;
   localparam int STEP_LG     = $clog2(DESC_BYTES);
   localparam int STAT_W      = 16;
   localparam int LEN_W       = 16;
   localparam int BUF_W       = 32;
   localparam int EMPTY_BIT   = 15;
   localparam int WRAP_BIT    = 13;
   localparam int ACT_BIT     = 24;
   localparam int CMD_W       = 32;

   typedef struct packed {
      logic [STAT_W-1:0] status;
      logic [LEN_W-1:0]  length;
      logic [BUF_W-1:0]  bufptr;
   } rxdesc_t;

   typedef enum logic [2:0] {
      WS_IDLE   = 3'd0,
      WS_FREQ   = 3'd1,
      WS_FWAIT  = 3'd2,
      WS_OFFER  = 3'd3,
      WS_RXWAIT = 3'd4,
      WS_WREQ   = 3'd5,
      WS_WWAIT  = 3'd6
   } walk_state_t;
endpackage

// File: rtl/rxring_cmd_flag.sv
module rxring_cmd_flag
   import rxring_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             wr_stb,
   input  logic [CMD_W-1:0] wr_data,
   input  logic             clr_stb,
   output logic             act,
   output logic [CMD_W-1:0] rdata
);
   logic act_q;
   logic unused_wdata;

   // written value plays no part: only the strobe arms the flag
   assign unused_wdata = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        act_q <= 1'b0;
      else if (!en)      act_q <= 1'b0;
      else if (wr_stb)   act_q <= 1'b1;
      else if (clr_stb)  act_q <= 1'b0;
   end

   assign act   = act_q;
   assign rdata = CMD_W'(act_q) << ACT_BIT;

   AST_WR_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      en && wr_stb |=> act) else $error("write did not arm"); // R1
   AST_EN_LOW_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !act) else $error("flag survived disable"); // R4
   AST_RDATA_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[ACT_BIT-1:0] == '0 && rdata[CMD_W-1:ACT_BIT+1] == '0) else $error("stray read bits"); // R5
   AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      en && wr_stb && clr_stb |=> act) else $error("clear beat set"); // R9
endmodule

// File: rtl/rxring_ring_idx.sv
module rxring_ring_idx
   import rxring_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [ADDR_W-1:0] base,
   input  logic              adv,
   input  logic              wrap,
   output logic [ADDR_W-1:0] addr
);
   localparam int PAD_W = ADDR_W - IDX_W - STEP_LG;

   logic [IDX_W-1:0]  idx_q;
   logic [ADDR_W-1:0] ofs;

   generate
      if (PAD_W < 0) begin : g_bad_width
         $error("ring index does not fit the address width");
      end
      if (PAD_W == 0) begin : g_ofs_exact
         assign ofs = {idx_q, {STEP_LG{1'b0}}};
      end else begin : g_ofs_pad
         assign ofs = {{PAD_W{1'b0}}, idx_q, {STEP_LG{1'b0}}};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      idx_q <= '0;
      else if (!en)    idx_q <= '0;
      else if (adv)    idx_q <= wrap ? '0 : idx_q + 1'b1;
   end

   assign addr = base + ofs;

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      en && adv && !wrap |=> idx_q == $past(idx_q) + 1'b1) else $error("bad step"); // R8
   AST_WRAP_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      en && adv && wrap |=> addr == base) else $error("wrap missed base"); // R8
   AST_DISABLE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> addr == base) else $error("index kept on disable"); // R4
endmodule

// File: rtl/rxring_walker.sv
module rxring_walker
   import rxring_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int ERR_W  = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic                 act,
   input  logic [ADDR_W-1:0]    cur_addr,
   output logic                 mem_req_valid,
   input  logic                 mem_req_ready,
   output logic                 mem_req_we,
   output logic [ADDR_W-1:0]    mem_req_addr,
   output logic [DESC_BITS-1:0] mem_req_wdata,
   input  logic                 mem_rsp_valid,
   input  logic [DESC_BITS-1:0] mem_rsp_data,
   output logic                 buf_valid,
   input  logic                 buf_ready,
   output logic [BUF_W-1:0]     buf_addr,
   input  logic                 done_valid,
   input  logic [LEN_W-1:0]     done_len,
   input  logic [ERR_W-1:0]     done_err,
   output logic                 clr_stb,
   output logic                 adv,
   output logic                 wrap
);
   localparam int KEEP_W = EMPTY_BIT - ERR_W;
   localparam int WRAP_K = WRAP_BIT - ERR_W;

   walk_state_t          st_q;
   rxdesc_t              rsp_d;
   logic [KEEP_W-1:0]    keep_q;
   logic [BUF_W-1:0]     ptr_q;
   logic [LEN_W-1:0]     len_q;
   logic [ERR_W-1:0]     err_q;
   logic [STAT_W-1:0]    wb_status;
   logic                 rsp_empty;
   logic                 unused_rsp;

   generate
      if (ERR_W < 1 || ERR_W > WRAP_BIT) begin : g_bad_err
         $error("error field must sit below the wrap bit");
      end
   endgenerate

   assign rsp_d      = rxdesc_t'(mem_rsp_data);
   assign rsp_empty  = rsp_d.status[EMPTY_BIT];
   assign unused_rsp = ^{rsp_d.length, rsp_d.status[ERR_W-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= WS_IDLE;
         keep_q <= '0;
         ptr_q  <= '0;
         len_q  <= '0;
         err_q  <= '0;
      end else if (!en) begin
         st_q <= WS_IDLE;
      end else begin
         unique case (st_q)
            WS_IDLE:   if (act) st_q <= WS_FREQ;
            WS_FREQ:   if (mem_req_ready) st_q <= WS_FWAIT;
            WS_FWAIT:  if (mem_rsp_valid) begin
                          if (rsp_empty) begin
                             keep_q <= rsp_d.status[EMPTY_BIT-1:ERR_W];
                             ptr_q  <= rsp_d.bufptr;
                             st_q   <= WS_OFFER;
                          end else begin
                             st_q <= WS_IDLE;
                          end
                       end
            WS_OFFER:  if (buf_ready) st_q <= WS_RXWAIT;
            WS_RXWAIT: if (done_valid) begin
                          len_q <= done_len;
                          err_q <= done_err;
                          st_q  <= WS_WREQ;
                       end
            WS_WREQ:   if (mem_req_ready) st_q <= WS_WWAIT;
            WS_WWAIT:  if (mem_rsp_valid) st_q <= WS_IDLE;
            default:   st_q <= WS_IDLE;
         endcase
      end
   end

   assign wb_status     = {1'b0, keep_q, err_q};
   assign mem_req_valid = en && (st_q == WS_FREQ || st_q == WS_WREQ);
   assign mem_req_we    = (st_q == WS_WREQ);
   assign mem_req_addr  = cur_addr;
   assign mem_req_wdata = {wb_status, len_q, ptr_q};
   assign buf_valid     = en && (st_q == WS_OFFER);
   assign buf_addr      = ptr_q;
   assign clr_stb       = en && (st_q == WS_FWAIT) && mem_rsp_valid && !rsp_empty;
   assign adv           = en && (st_q == WS_WWAIT) && mem_rsp_valid;
   assign wrap          = keep_q[WRAP_K];

   AST_FETCH_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_we |-> en && act) else $error("fetch while idle"); // R2
   AST_NONEMPTY_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
      en && st_q == WS_FWAIT && mem_rsp_valid && !rsp_empty |=> st_q == WS_IDLE && !mem_req_valid) else $error("walk continued"); // R3
   AST_OFFER_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      en && st_q == WS_FWAIT && mem_rsp_valid && rsp_empty |=> !en || (buf_valid && buf_addr == $past(rsp_d.bufptr))) else $error("buffer not offered"); // R6
   AST_WB_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_we |-> !mem_req_wdata[DESC_BITS-1]) else $error("writeback kept empty bit"); // R7
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> !en || (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata))) else $error("request changed"); // R10
endmodule

// File: rtl/rxring_poll_ctrl.sv
module rxring_poll_ctrl
   import rxring_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 10,
   parameter int ERR_W  = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 eth_en,
   input  logic                 cmd_wr,
   input  logic [CMD_W-1:0]     cmd_wdata,
   output logic [CMD_W-1:0]     cmd_rdata,
   input  logic [ADDR_W-1:0]    ring_base,
   output logic                 mem_req_valid,
   input  logic                 mem_req_ready,
   output logic                 mem_req_we,
   output logic [ADDR_W-1:0]    mem_req_addr,
   output logic [DESC_BITS-1:0] mem_req_wdata,
   input  logic                 mem_rsp_valid,
   input  logic [DESC_BITS-1:0] mem_rsp_data,
   output logic                 buf_valid,
   input  logic                 buf_ready,
   output logic [BUF_W-1:0]     buf_addr,
   input  logic                 done_valid,
   input  logic [LEN_W-1:0]     done_len,
   input  logic [ERR_W-1:0]     done_err
);
   logic              act;
   logic              clr_stb;
   logic              adv;
   logic              wrap;
   logic [ADDR_W-1:0] cur_addr;

   rxring_cmd_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (eth_en),
      .wr_stb  (cmd_wr),
      .wr_data (cmd_wdata),
      .clr_stb (clr_stb),
      .act     (act),
      .rdata   (cmd_rdata)
   );

   rxring_ring_idx #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_idx (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (eth_en),
      .base  (ring_base),
      .adv   (adv),
      .wrap  (wrap),
      .addr  (cur_addr)
   );

   rxring_walker #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) u_walk (
      .clk           (clk),
      .rst_n         (rst_n),
      .en            (eth_en),
      .act           (act),
      .cur_addr      (cur_addr),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_we    (mem_req_we),
      .mem_req_addr  (mem_req_addr),
      .mem_req_wdata (mem_req_wdata),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .buf_valid     (buf_valid),
      .buf_ready     (buf_ready),
      .buf_addr      (buf_addr),
      .done_valid    (done_valid),
      .done_len      (done_len),
      .done_err      (done_err),
      .clr_stb       (clr_stb),
      .adv           (adv),
      .wrap          (wrap)
   );
endmodule

// File: tb/rxring_poll_ctrl_tb_top.sv
module rxring_poll_ctrl_tb_top;
   localparam int ADDR_W = 32;
   localparam int ERR_W  = 6;
   localparam logic [31:0] BASE = 32'h0000_1000;

   // table: fetched status, frame length, error flags, expected status, buffer
   localparam logic [15:0] V_ST  [4] = '{16'h8000, 16'hC03F, 16'h9FC0, 16'hA000};
   localparam logic [15:0] V_LEN [4] = '{16'd64, 16'd1518, 16'h0005, 16'hFFFF};
   localparam logic [5:0]  V_ERR [4] = '{6'h00, 6'h2A, 6'h01, 6'h3F};
   localparam logic [15:0] V_EXP [4] = '{16'h0000, 16'h402A, 16'h1FC1, 16'h203F};
   localparam logic [31:0] V_BUF [4] = '{32'hA000_0000, 32'hA000_0100, 32'hA000_0200, 32'hA000_0300};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic eth_en = 1'b1;
   logic wr_task = 1'b0;
   logic col_wr = 1'b0;
   logic cmd_wr;
   logic [31:0] cmd_wdata = '0;
   logic [31:0] cmd_rdata;
   logic mem_req_valid, mem_req_we;
   logic mem_req_ready = 1'b0;
   logic [ADDR_W-1:0] mem_req_addr;
   logic [63:0] mem_req_wdata;
   logic mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_data = '0;
   logic buf_valid;
   logic buf_ready = 1'b0;
   logic [31:0] buf_addr;
   logic done_valid = 1'b0;
   logic [15:0] done_len = '0;
   logic [ERR_W-1:0] done_err = '0;

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   assign cmd_wr = wr_task | col_wr;

   always #10 clk = ~clk;

   rxring_poll_ctrl #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .eth_en(eth_en), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
      .cmd_rdata(cmd_rdata), .ring_base(BASE), .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
      .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .buf_valid(buf_valid), .buf_ready(buf_ready), .buf_addr(buf_addr),
      .done_valid(done_valid), .done_len(done_len), .done_err(done_err)
   );

   // descriptor memory model
   logic [63:0] dmem [16];
   logic [63:0] wb_data_log [16];
   logic [31:0] wb_addr_log [16];
   int fetch_cnt = 0, wb_cnt = 0, mem_lat = 1, cnt = 0;
   int stall_seen = 0, stall_viol = 0;
   bit busy = 0, seen = 0, s_we = 0, was_we = 0, hold_chk = 0;
   bit stall_on = 0, stall_tog = 0, col_mode = 0;
   logic [31:0] s_addr = '0, last_fetch = '0;
   logic [63:0] s_data = '0, rd_data = '0;

   always @(negedge clk) begin
      mem_rsp_valid = 1'b0;
      col_wr = 1'b0;
      if (!rst_n) begin
         busy = 0; seen = 0; hold_chk = 0; mem_req_ready = 1'b0;
      end else begin
         if (seen && mem_req_ready) begin
            busy = 1; cnt = mem_lat; was_we = s_we;
            if (s_we) begin
               wb_addr_log[wb_cnt[3:0]] = s_addr;
               wb_data_log[wb_cnt[3:0]] = s_data;
               dmem[(s_addr - BASE) >> 3 & 15] = s_data;
               wb_cnt++;
            end else begin
               fetch_cnt++;
               last_fetch = s_addr;
               rd_data = dmem[(s_addr - BASE) >> 3 & 15];
            end
         end
         if (busy) begin
            if (cnt <= 1) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data = rd_data;
               busy = 0;
               if (!was_we && col_mode) begin col_wr = 1'b1; col_mode = 0; end
            end else cnt--;
         end
         if (hold_chk && mem_req_valid &&
             (mem_req_addr != s_addr || mem_req_we != s_we || (s_we && mem_req_wdata != s_data)))
            stall_viol++;
         stall_tog = ~stall_tog;
         seen = mem_req_valid; s_addr = mem_req_addr; s_we = mem_req_we; s_data = mem_req_wdata;
         mem_req_ready = !busy && mem_req_valid && (!stall_on || stall_tog);
         hold_chk = mem_req_valid && !mem_req_ready;
         if (hold_chk) stall_seen++;
      end
   end

   // frame-receive model
   logic [15:0] f_len [32];
   logic [5:0]  f_err [32];
   logic [31:0] buf_log [32];
   int frames = 0, fidx = 0, fcnt = 0, frame_dly = 3;
   bit fbusy = 0, fseen = 0;
   logic [31:0] fs_addr = '0;

   always @(negedge clk) begin
      done_valid = 1'b0;
      if (!rst_n) begin
         fbusy = 0; fseen = 0; buf_ready = 1'b0;
      end else begin
         if (fseen && buf_ready) begin
            buf_log[frames[4:0]] = fs_addr; fidx = frames; frames++;
            fbusy = 1; fcnt = frame_dly;
         end
         if (fbusy) begin
            if (fcnt <= 1) begin
               done_valid = 1'b1; done_len = f_len[fidx[4:0]]; done_err = f_err[fidx[4:0]]; fbusy = 0;
            end else fcnt--;
         end
         fseen = buf_valid; fs_addr = buf_addr;
         buf_ready = buf_valid && !fbusy;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] actv, input logic [63:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, actv, expv);
      end
   endtask

   task automatic cmd_write(input logic [31:0] d);
      @(posedge clk); #2; wr_task = 1'b1; cmd_wdata = d;
      @(posedge clk); #2; wr_task = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL R10 watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 32; i++) begin f_len[i] = 16'd100; f_err[i] = '0; end
      for (int i = 0; i < 16; i++) dmem[i] = '0;
      for (int i = 0; i < 4; i++) begin
         dmem[i] = {V_ST[i], 16'h0000, V_BUF[i]};
         f_len[i] = V_LEN[i]; f_err[i] = V_ERR[i];
      end
      idle(3);
      rst_n = 1'b1;
      idle(1);
      chk(cmd_rdata == 32'h0, "R5", "reset read value", 64'(cmd_rdata), 64'h0);
      chk(!mem_req_valid && !buf_valid, "R2", "no request after reset", 64'(mem_req_valid), 64'h0);
      idle(20);
      chk(fetch_cnt == 0, "R2", "no fetch without a write", 64'(fetch_cnt), 64'h0);

      // table run with back-pressure and longer latency
      stall_on = 1; mem_lat = 4;
      cmd_write(32'h0100_0000);
      for (int k = 0; k < 3000 && !(fetch_cnt == 5 && !cmd_rdata[24]); k++) idle(1);
      for (int i = 0; i < 4; i++) begin
         chk(wb_addr_log[i] == BASE + 32'(i * 8), "R8", "writeback address", 64'(wb_addr_log[i]), 64'(BASE + 32'(i * 8)));
         chk(wb_data_log[i] == {V_EXP[i], V_LEN[i], V_BUF[i]}, "R7", "writeback word",
             wb_data_log[i], {V_EXP[i], V_LEN[i], V_BUF[i]});
         chk(buf_log[i] == V_BUF[i], "R6", "offered buffer", 64'(buf_log[i]), 64'(V_BUF[i]));
      end
      chk(last_fetch == BASE, "R8", "wrap back to base", 64'(last_fetch), 64'(BASE));
      chk(fetch_cnt == 5 && wb_cnt == 4, "R3", "halt on written-back slot", 64'(fetch_cnt), 64'd5);
      chk(!cmd_rdata[24], "R3", "flag clear after non-empty", 64'(cmd_rdata), 64'h0);
      chk(stall_seen > 0 && stall_viol == 0, "R10", "request held under stall", 64'(stall_viol), 64'h0);
      stall_on = 0; mem_lat = 1;

      // write data plays no part
      cmd_write(32'h0000_0000);
      chk(cmd_rdata[24], "R1", "zero data still arms", 64'(cmd_rdata), 64'h0100_0000);
      idle(40);
      chk(fetch_cnt == 6 && !cmd_rdata[24], "R3", "single fetch then stop", 64'(fetch_cnt), 64'd6);
      cmd_write(32'hFFFF_FFFF);
      chk(cmd_rdata == 32'h0100_0000, "R5", "only bit 24 reads back", 64'(cmd_rdata), 64'h0100_0000);
      idle(40);

      // collision of write with clear-on-non-empty
      col_mode = 1;
      cmd_write(32'h0000_1234);
      idle(60);
      chk(fetch_cnt == 9, "R9", "set wins, ring polled again", 64'(fetch_cnt), 64'd9);
      chk(!cmd_rdata[24], "R9", "flag clears on the repoll", 64'(cmd_rdata), 64'h0);

      // enable loss mid-frame
      dmem[0] = {16'h8000, 16'h0, 32'hB000_0000};
      dmem[1] = {16'h8000, 16'h0, 32'hB000_0100};
      dmem[2] = '0;
      frame_dly = 3;
      cmd_write(32'h0);
      for (int k = 0; k < 500 && frames < 5; k++) idle(1);
      frame_dly = 80;
      for (int k = 0; k < 500 && frames < 6; k++) idle(1);
      idle(5);
      eth_en = 1'b0;
      idle(1);
      chk(!cmd_rdata[24] && !mem_req_valid && !buf_valid, "R4", "disable drops flag and requests",
          64'(cmd_rdata), 64'h0);
      cmd_write(32'h0100_0000);
      chk(!cmd_rdata[24], "R4", "write ignored while disabled", 64'(cmd_rdata), 64'h0);
      idle(100);
      chk(wb_cnt == 5, "R4", "abandoned frame not written back", 64'(wb_cnt), 64'd5);
      dmem[0] = {16'h8000, 16'h0, 32'hC000_0000};
      dmem[1] = '0;
      frame_dly = 3;
      eth_en = 1'b1;
      idle(10);
      chk(fetch_cnt == 11, "R2", "no fetch after re-enable alone", 64'(fetch_cnt), 64'd11);
      cmd_write(32'h0);
      for (int k = 0; k < 500 && !(wb_cnt == 6 && fetch_cnt == 13 && !cmd_rdata[24]); k++) idle(1);
      chk(wb_addr_log[5] == BASE, "R4", "index reset to base", 64'(wb_addr_log[5]), 64'(BASE));
      chk(buf_log[6] == 32'hC000_0000, "R6", "buffer from base slot", 64'(buf_log[6]), 64'hC000_0000);
      chk(last_fetch == BASE + 32'd8 && !cmd_rdata[24], "R8", "step of 8 then halt",
          64'(last_fetch), 64'(BASE + 32'd8));

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule